// File: doc/BRIEF.md
# Power-Pulsing Phase Controller

This block sequences the supply and bias enables of a multi-channel detector front-end chip across four power phases: sampling, non-sampling, read and sleep. A fast synchronous command arrives as a 4-bit code with a valid strobe. The controller decodes it and moves to the requested phase. From the current phase it drives one enable per domain: preamplifier, shaper, ADC bias, gated ADC clock, signal-processing logic, RAM, the retention select of the configuration storage, and the link port.

The configuration storage is never switched off. In sleep it only drops to a retention supply. The processing logic is fully removed in sleep. Leaving sleep starts a wake-up interval: digital logic and RAM come up first, and the analog domains stay down until a programmable count has elapsed. Status outputs report the current phase, whether the controller is ready, and a one-cycle flag for each rejected command.

Top module: `pwr_phase_ctrl`

## Requirements
- R1: While reset is held and after it is released, the controller is in sleep (phase_o = 2'b00), ready_o is 1, cmd_err_o is 0, cfg_retain_o is 1, link_en_o is 1, and every other enable and adc_clk_o is 0.
- R2: A strobed command takes effect on the clock edge that samples it. Code 4'h1 selects sampling (phase_o = 2'b01), 4'h2 selects non-sampling (2'b10), 4'h3 selects read (2'b11), and 4'h4 selects sleep (2'b00).
- R3: In sampling with ready_o high, the preamplifier, shaper, ADC bias, processing, RAM and link enables are all 1, and cfg_retain_o is 0.
- R4: In non-sampling and in read, the preamplifier, shaper and ADC bias enables are 0, while the processing, RAM and link enables are 1 and cfg_retain_o is 0.
- R5: In sleep, the preamplifier, shaper, ADC bias, processing and RAM enables are 0, link_en_o is 1, and cfg_retain_o is 1 (configuration held at retention supply).
- R6: adc_clk_o is never high while clk is low. Its gate is updated only at falling clock edges, so during a high phase of clk, adc_clk_o equals the ADC bias enable as it stood before the preceding rising edge.
- R7: A strobed code other than 4'h1 to 4'h4 leaves the phase unchanged and raises cmd_err_o for exactly the next cycle. An unstrobed code has no effect.
- R8: A command for a non-sleep phase that is received in sleep drops ready_o for wake_cycles+1 cycles, where wake_cycles is sampled with that command. During this interval processing and RAM are enabled, cfg_retain_o is 0, and the preamplifier, shaper and ADC stay down.
- R9: A sleep command during wake-up returns the controller to sleep at once with ready_o high. Any other legal command during wake-up changes the target phase without restarting the count. A command for the phase already held changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the source of the ADC clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code |
| wake_cycles | input | 8 | Wake-up count applied when leaving sleep |
| phase_o | output | 2 | Current (or target) phase |
| ready_o | output | 1 | Low during the wake-up interval |
| cmd_err_o | output | 1 | One-cycle pulse after an unknown code |
| preamp_en_o | output | 1 | Preamplifier bias enable |
| shaper_en_o | output | 1 | Shaper bias enable |
| adc_bias_en_o | output | 1 | ADC bias enable |
| adc_clk_o | output | 1 | Glitch-free gated ADC clock |
| dsp_en_o | output | 1 | Processing logic supply enable |
| ram_en_o | output | 1 | RAM supply enable |
| cfg_retain_o | output | 1 | 1 = configuration storage at retention supply, 0 = full supply |
| link_en_o | output | 1 | Link port enable |

## Verification
The assertions assume that cmd_code and wake_cycles are stable whenever they are sampled with cmd_valid, and that the clock is free-running with no pulse shorter than half a period. They also assume that a phase of 2'b00 is entered only by command or by reset. The stimulus changes inputs only at falling edges and holds them through the next rising edge. It uses a fixed scenario list followed by a pseudo-random run that keeps wake_cycles below eight, so that wake-ups end and commands regularly arrive both during wake-up and after it.

// File: rtl/pwr_phase_pkg.sv
package pwr_phase_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [1:0] {
        PH_SLEEP  = 2'b00,
        PH_SAMPLE = 2'b01,
        PH_IDLE   = 2'b10,
        PH_READ   = 2'b11
    } phase_e;

    localparam logic [CMD_W-1:0] OP_SAMPLE = 4'h1;
    localparam logic [CMD_W-1:0] OP_IDLE   = 4'h2;
    localparam logic [CMD_W-1:0] OP_READ   = 4'h3;
    localparam logic [CMD_W-1:0] OP_SLEEP  = 4'h4;

    typedef struct packed {
        logic   legal;
        phase_e target;
    } cmd_dec_t;

    typedef struct packed {
        logic preamp;
        logic shaper;
        logic adc;
        logic dsp;
        logic ram;
        logic cfg_retain;
        logic link;
    } dom_en_t;

    function automatic cmd_dec_t decode_op(input logic [CMD_W-1:0] op);
        cmd_dec_t d;
        d.legal  = 1'b1;
        d.target = PH_SLEEP;
        case (op)
            OP_SAMPLE: d.target = PH_SAMPLE;
            OP_IDLE:   d.target = PH_IDLE;
            OP_READ:   d.target = PH_READ;
            OP_SLEEP:  d.target = PH_SLEEP;
            default:   d.legal  = 1'b0;
        endcase
        return d;
    endfunction

    function automatic dom_en_t phase_domains(input phase_e ph, input logic waking);
        dom_en_t e;
        e.link       = 1'b1;
        e.cfg_retain = (ph == PH_SLEEP);
        e.dsp        = (ph != PH_SLEEP);
        e.ram        = (ph != PH_SLEEP);
        e.preamp     = (ph == PH_SAMPLE) && !waking;
        e.shaper     = (ph == PH_SAMPLE) && !waking;
        e.adc        = (ph == PH_SAMPLE) && !waking;
        return e;
    endfunction

endpackage

// File: rtl/ppc_cmd_decode.sv
module ppc_cmd_decode
    import pwr_phase_pkg::*;
#(
    parameter int OP_W = CMD_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_code,
    output logic            cmd_go,
    output phase_e          cmd_tgt,
    output logic            cmd_err_q
);
    cmd_dec_t dec;

    always_comb begin
        dec     = decode_op(cmd_code);
        cmd_go  = cmd_valid && dec.legal;
        cmd_tgt = dec.target;
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_err_q <= 1'b0;
        else     cmd_err_q <= cmd_valid && !dec.legal;
    end
endmodule

// File: rtl/ppc_phase_fsm.sv
module ppc_phase_fsm
    import pwr_phase_pkg::*;
#(
    parameter int WAKE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_go,
    input  phase_e            cmd_tgt,
    input  logic [WAKE_W-1:0] wake_cycles,
    output phase_e            phase_q,
    output logic              waking_q
);
    logic [WAKE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_SLEEP;
            waking_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            if (waking_q) begin
                if (cnt_q == '0) waking_q <= 1'b0;
                else             cnt_q    <= cnt_q - 1'b1;
            end
            if (cmd_go) begin
                if (cmd_tgt == PH_SLEEP) begin
                    phase_q  <= PH_SLEEP;
                    waking_q <= 1'b0;
                end else if (phase_q == PH_SLEEP) begin
                    phase_q  <= cmd_tgt;
                    waking_q <= 1'b1;
                    cnt_q    <= wake_cycles;
                end else begin
                    phase_q  <= cmd_tgt;
                end
            end
        end
    end
endmodule

// File: rtl/ppc_clk_gate.sv
module ppc_clk_gate (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic gclk
);
    logic gate_q;

    always_ff @(negedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= enable;
    end

    assign gclk = clk & gate_q;
endmodule

// File: rtl/pwr_phase_ctrl.sv
module pwr_phase_ctrl
    import pwr_phase_pkg::*;
#(
    parameter int WAKE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic [WAKE_W-1:0] wake_cycles,
    output logic [1:0]        phase_o,
    output logic              ready_o,
    output logic              cmd_err_o,
    output logic              preamp_en_o,
    output logic              shaper_en_o,
    output logic              adc_bias_en_o,
    output logic              adc_clk_o,
    output logic              dsp_en_o,
    output logic              ram_en_o,
    output logic              cfg_retain_o,
    output logic              link_en_o
);
    logic    cmd_go;
    phase_e  cmd_tgt;
    phase_e  phase_q;
    logic    waking_q;
    dom_en_t dom;

    ppc_cmd_decode #(.OP_W(CMD_W)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_go    (cmd_go),
        .cmd_tgt   (cmd_tgt),
        .cmd_err_q (cmd_err_o)
    );

    ppc_phase_fsm #(.WAKE_W(WAKE_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_go      (cmd_go),
        .cmd_tgt     (cmd_tgt),
        .wake_cycles (wake_cycles),
        .phase_q     (phase_q),
        .waking_q    (waking_q)
    );

    always_comb dom = phase_domains(phase_q, waking_q);

    ppc_clk_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .enable (dom.adc),
        .gclk   (adc_clk_o)
    );

    assign phase_o       = phase_q;
    assign ready_o       = !waking_q;
    assign preamp_en_o   = dom.preamp;
    assign shaper_en_o   = dom.shaper;
    assign adc_bias_en_o = dom.adc;
    assign dsp_en_o      = dom.dsp;
    assign ram_en_o      = dom.ram;
    assign cfg_retain_o  = dom.cfg_retain;
    assign link_en_o     = dom.link;
endmodule

// File: rtl/pwr_phase_ctrl_chk.sv
module pwr_phase_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [3:0] cmd_code,
    input logic [1:0] phase_o,
    input logic       ready_o,
    input logic       cmd_err_o,
    input logic       preamp_en_o,
    input logic       shaper_en_o,
    input logic       adc_bias_en_o,
    input logic       adc_clk_o,
    input logic       dsp_en_o,
    input logic       ram_en_o,
    input logic       cfg_retain_o,
    input logic       link_en_o
);
    logic bad_cmd;
    assign bad_cmd = cmd_valid && !(cmd_code inside {4'h1, 4'h2, 4'h3, 4'h4});

    AST_SAMPLE_ALL_ON: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'b01 && ready_o) |-> (preamp_en_o && shaper_en_o && adc_bias_en_o
                                           && dsp_en_o && ram_en_o && link_en_o && !cfg_retain_o)); // R3

    AST_IDLE_READ_ANALOG_OFF: assert property (@(posedge clk) disable iff (rst)
        phase_o[1] |-> (!preamp_en_o && !shaper_en_o && !adc_bias_en_o
                        && dsp_en_o && ram_en_o && link_en_o && !cfg_retain_o)); // R4

    AST_SLEEP_ONLY_LINK: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'b00) |-> (!preamp_en_o && !shaper_en_o && !adc_bias_en_o
                                && !dsp_en_o && !ram_en_o && cfg_retain_o && link_en_o && ready_o)); // R5

    always_comb begin
        if (!clk) begin
            AST_ADC_CLK_LOW: assert (!adc_clk_o); // R6
        end
    end

    AST_BAD_CMD_FLAG: assert property (@(posedge clk) disable iff (rst)
        bad_cmd |=> cmd_err_o); // R7

    AST_BAD_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        bad_cmd |=> $stable(phase_o)); // R7

    AST_WAKE_DIGITAL_FIRST: assert property (@(posedge clk) disable iff (rst)
        !ready_o |-> (dsp_en_o && ram_en_o && !adc_bias_en_o && !preamp_en_o && !shaper_en_o)); // R8

    AST_WAKE_STARTS: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'b00 && cmd_valid && cmd_code inside {4'h1, 4'h2, 4'h3}) |=> !ready_o); // R8

    AST_SLEEP_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 4'h4) |=> (phase_o == 2'b00 && ready_o)); // R9
endmodule

bind pwr_phase_ctrl pwr_phase_ctrl_chk u_chk (.*);

// File: tb/pwr_phase_ctrl_test.sv
`timescale 1ns/1ps
module pwr_phase_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_code = 4'h0;
    logic [7:0] wake_cycles = 8'h0;
    logic [1:0] phase_o;
    logic ready_o, cmd_err_o, preamp_en_o, shaper_en_o, adc_bias_en_o, adc_clk_o;
    logic dsp_en_o, ram_en_o, cfg_retain_o, link_en_o;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    // reference model state
    int m_phase = 0;
    bit m_wake = 0;
    int m_cnt = 0;
    bit m_err = 0;
    bit m_gate = 0;

    always #2.5 clk = ~clk;

    pwr_phase_ctrl uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .wake_cycles(wake_cycles), .phase_o(phase_o), .ready_o(ready_o),
        .cmd_err_o(cmd_err_o), .preamp_en_o(preamp_en_o), .shaper_en_o(shaper_en_o),
        .adc_bias_en_o(adc_bias_en_o), .adc_clk_o(adc_clk_o), .dsp_en_o(dsp_en_o),
        .ram_en_o(ram_en_o), .cfg_retain_o(cfg_retain_o), .link_en_o(link_en_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit m_analog();
        return (m_phase == 1) && !m_wake;
    endfunction

    task automatic model_edge(input bit v, input bit [3:0] c, input bit [7:0] w);
        int tgt;
        m_gate = m_analog();
        if (rst) begin
            m_phase = 0; m_wake = 0; m_cnt = 0; m_err = 0; m_gate = 0;
            return;
        end
        m_err = v && !(c >= 4'h1 && c <= 4'h4);
        if (m_wake) begin
            if (m_cnt == 0) m_wake = 0;
            else m_cnt = m_cnt - 1;
        end
        if (v && c >= 4'h1 && c <= 4'h4) begin
            tgt = (c == 4'h4) ? 0 : int'(c);
            if (tgt == 0) begin
                m_phase = 0; m_wake = 0;
            end else if (m_phase == 0) begin
                m_phase = tgt; m_wake = 1; m_cnt = int'(w);
            end else begin
                m_phase = tgt;
            end
        end
    endtask

    task automatic compare();
        string et;
        bit an;
        an = m_analog();
        if (rst) et = "R1";
        else if (m_wake) et = "R8";
        else if (m_phase == 0) et = "R5";
        else if (m_phase == 1) et = "R3";
        else et = "R4";
        chk(rst ? "R1" : "R2", "phase", int'(phase_o), m_phase);
        chk(rst ? "R1" : "R8", "ready", int'(ready_o), int'(!m_wake));
        chk(rst ? "R1" : "R7", "cmd_err", int'(cmd_err_o), int'(m_err));
        chk(et, "preamp", int'(preamp_en_o), int'(an));
        chk(et, "shaper", int'(shaper_en_o), int'(an));
        chk(et, "adc_bias", int'(adc_bias_en_o), int'(an));
        chk(et, "dsp", int'(dsp_en_o), int'(m_phase != 0));
        chk(et, "ram", int'(ram_en_o), int'(m_phase != 0));
        chk(et, "cfg_retain", int'(cfg_retain_o), int'(m_phase == 0));
        chk(et, "link", int'(link_en_o), 1);
        chk(rst ? "R1" : "R6", "adc_clk_high", int'(adc_clk_o), int'(m_gate));
    endtask

    task automatic step(input bit v, input bit [3:0] c, input bit [7:0] w);
        @(negedge clk);
        cmd_valid = v; cmd_code = c; wake_cycles = w;
        #1.0;
        chk("R6", "adc_clk_low", int'(adc_clk_o), 0);
        @(posedge clk);
        model_edge(v, c, w);
        #1.25;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'h0, 8'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        // R1: reset state
        idle(3);
        @(negedge clk); rst = 1'b0;
        idle(2);
        chk("R1", "phase after reset", int'(phase_o), 0);
        chk("R1", "ready after reset", int'(ready_o), 1);

        // R2/R8: wake to sampling with count 3
        step(1'b1, 4'h1, 8'd3);
        idle(6);
        chk("R3", "sampling preamp", int'(preamp_en_o), 1);
        // R4: non-sampling, read
        step(1'b1, 4'h2, 8'd9); idle(2);
        step(1'b1, 4'h3, 8'd9); idle(2);
        chk("R4", "read adc", int'(adc_bias_en_o), 0);
        // R7: unknown codes, and unstrobed code
        step(1'b1, 4'h0, 8'd0);
        step(1'b1, 4'h5, 8'd0);
        step(1'b1, 4'hF, 8'd0);
        step(1'b0, 4'h1, 8'd0);
        chk("R7", "phase held", int'(phase_o), 3);
        // R9: same phase command
        step(1'b1, 4'h3, 8'd0);
        chk("R9", "same phase", int'(phase_o), 3);
        // R5: sleep
        step(1'b1, 4'h4, 8'd0); idle(2);
        chk("R5", "sleep retention", int'(cfg_retain_o), 1);
        // R9: sleep during wake aborts
        step(1'b1, 4'h1, 8'd6); idle(2);
        step(1'b1, 4'h4, 8'd0);
        chk("R9", "abort to sleep", int'(phase_o), 0);
        chk("R9", "abort ready", int'(ready_o), 1);
        // R9: retarget during wake keeps count
        step(1'b1, 4'h3, 8'd4); idle(1);
        step(1'b1, 4'h1, 8'd200);
        idle(1);
        chk("R9", "retarget still waking", int'(ready_o), 0);
        idle(2);
        chk("R9", "retarget count kept", int'(ready_o), 1);
        // R8: zero wake count
        step(1'b1, 4'h4, 8'd0);
        step(1'b1, 4'h1, 8'd0);
        chk("R8", "zero count waking", int'(ready_o), 0);
        idle(1);
        chk("R8", "zero count ready", int'(ready_o), 1);

        // pseudo-random run
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            bit v;
            bit [3:0] c;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            v = lf[0] & lf[1];
            c = lf[2] ? (lf[6:3] & 4'h7) : lf[6:3];
            step(v, c, {5'b0, lf[10:8]});
        end
        // reset mid-run returns to sleep (R1)
        @(negedge clk); rst = 1'b1;
        idle(2);
        @(negedge clk); rst = 1'b0;
        idle(1);
        chk("R1", "sleep after re-reset", int'(phase_o), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule